// File: doc/BRIEF.md
# Microprogram Sequencer with Writable Control Store

This block steps a microprogram. It holds an 8-bit micro program counter and a 256-word control store whose words are 32 bits wide. Each word that leaves the store is held in a microinstruction register, and that register drives one full processor cycle. In every cycle the sequencer chooses the next counter value from three inputs: a two-bit branch-condition field in the held word, an absolute target in the low byte of the same word, and the negative and zero flags that the ALU produces in that cycle.

The control store can be written only while the sequencer is held in reset. It is loaded through a write-enable, address and data port, so no initialisation file is needed.

The controller has two named states:
- `SQ_LOAD`: the block is in reset and the store may be written.
- `SQ_RUN`: the block is stepping.

Transitions:
- An active reset at any clock edge moves the block to `SQ_LOAD`.
- The first edge with reset low moves `SQ_LOAD` to `SQ_RUN`. That edge fetches word 0 and leaves the counter at 0.
- Every later edge stays in `SQ_RUN`. It updates the counter and fetches the word at the new counter value.

Top module: `useq_sequencer`

## Requirements
- R1: At an edge where `rst` is high, the counter becomes 0 and the microinstruction register becomes all zeros (a no-operation word).
- R2: At the first edge with `rst` low after reset, the counter stays 0 and the microinstruction register loads store word 0.
- R3: At every running edge, the microinstruction register loads the store word at the counter value chosen at that edge.
- R4: When the condition field (bits 30:29) is 0, the next counter value is the current value plus one, and 255 wraps to 0.
- R5: When the condition field is 1, the next counter value is the target (bits 7:0) if `flag_n` is 1 at that edge, and the current value plus one otherwise.
- R6: When the condition field is 2, the next counter value is the target if `flag_z` is 1 at that edge, and the current value plus one otherwise.
- R7: When the condition field is 3, the next counter value is always the target.
- R8: At an edge where both `rst` and `cs_we` are high, store word `cs_waddr` takes the value `cs_wdata`.
- R9: A write attempted while `rst` is low leaves the store unchanged. Later fetches of that address return the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; store write window |
| cs_we | input | 1 | Control-store write enable |
| cs_waddr | input | 8 | Control-store write address |
| cs_wdata | input | 32 | Control-store write data |
| flag_n | input | 1 | ALU negative flag of the current cycle |
| flag_z | input | 1 | ALU zero flag of the current cycle |
| mpc | output | 8 | Micro program counter, addresses the store |
| mir | output | 32 | Microinstruction register |

## Verification
Every result of this block is due at the first rising edge after its stimulus. A store write, a reset, a release from reset and a flag value together with the held word each take effect at that one edge. The bench drives all inputs at the falling edge and compares `mpc` and `mir` at the following falling edge, after exactly one rising edge has passed. Its model advances one step for each rising edge: the next counter value comes from the modelled held word and the flags driven in that half cycle, and the next held word is the modelled store entry at that counter value.

// File: rtl/useq_pkg.sv
package useq_pkg;

    // Controller states
    typedef enum logic {
        SQ_LOAD = 1'b0,
        SQ_RUN  = 1'b1
    } sq_state_e;

    // Branch-condition codes held in the microinstruction
    typedef enum logic [1:0] {
        BR_NONE   = 2'd0,
        BR_NEG    = 2'd1,
        BR_ZERO   = 2'd2,
        BR_ALWAYS = 2'd3
    } br_cond_e;

    // Bit position of the condition field (two bits wide)
    localparam int COND_LSB = 29;
    localparam int COND_W   = 2;

endpackage

// File: rtl/useq_store.sv
module useq_store #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R8
    store_write_lands_chk: assert property (@(posedge clk)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] cur,
    input  br_cond_e      cond,
    input  logic [AW-1:0] target,
    input  logic          flag_n,
    input  logic          flag_z,
    output logic [AW-1:0] nxt
);
    logic take;

    always_comb begin
        unique case (cond)
            BR_NONE:   take = 1'b0;
            BR_NEG:    take = flag_n;
            BR_ZERO:   take = flag_z;
            BR_ALWAYS: take = 1'b1;
            default:   take = 1'b0;
        endcase
    end

    assign nxt = take ? target : (cur + AW'(1));

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] nxt,
    input  logic [DW-1:0] rd_data,
    input  logic          flag_n,
    input  logic          flag_z,
    output logic [AW-1:0] fetch_addr,
    output logic [AW-1:0] mpc_q,
    output logic [DW-1:0] mir_q
);
    sq_state_e st_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SQ_LOAD;
        end else begin
            unique case (st_q)
                SQ_LOAD: st_q <= SQ_RUN;
                SQ_RUN:  st_q <= SQ_RUN;
                default: st_q <= SQ_LOAD;
            endcase
        end
    end

    // Fetch address: word at the current counter on the priming edge,
    // word at the chosen next counter once running
    assign fetch_addr = (st_q == SQ_RUN) ? nxt : mpc_q;

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mpc_q <= '0;
            mir_q <= '0;
        end else begin
            unique case (st_q)
                SQ_LOAD: begin
                    mpc_q <= mpc_q;
                    mir_q <= rd_data;
                end
                SQ_RUN: begin
                    mpc_q <= nxt;
                    mir_q <= rd_data;
                end
                default: begin
                    mpc_q <= '0;
                    mir_q <= '0;
                end
            endcase
        end
    end

    br_cond_e       cur_cond;
    logic [AW-1:0]  cur_tgt;
    assign cur_cond = br_cond_e'(mir_q[COND_LSB +: COND_W]);
    assign cur_tgt  = mir_q[AW-1:0];

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (mpc_q == '0 && mir_q == '0));

    // R2
    prime_holds_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_LOAD) |=> (mpc_q == '0));

    // R4
    seq_increment_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_RUN && cur_cond == BR_NONE) |=> (mpc_q == $past(mpc_q) + AW'(1)));

    // R5
    neg_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_RUN && cur_cond == BR_NEG && flag_n) |=> (mpc_q == $past(cur_tgt)));

    // R6
    zero_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_RUN && cur_cond == BR_ZERO && flag_z) |=> (mpc_q == $past(cur_tgt)));

    // R7
    always_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_RUN && cur_cond == BR_ALWAYS) |=> (mpc_q == $past(cur_tgt)));

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_we,
    input  logic [AW-1:0] cs_waddr,
    input  logic [DW-1:0] cs_wdata,
    input  logic          flag_n,
    input  logic          flag_z,
    output logic [AW-1:0] mpc,
    output logic [DW-1:0] mir
);
    logic [AW-1:0] nxt;
    logic [AW-1:0] fetch_addr;
    logic [DW-1:0] rd_data;
    logic          store_we;

    // Writes accepted only inside the reset window (R9)
    assign store_we = cs_we & rst;

    useq_store #(.AW(AW), .DW(DW)) u_store (
        .clk   (clk),
        .we    (store_we),
        .waddr (cs_waddr),
        .wdata (cs_wdata),
        .raddr (fetch_addr),
        .rdata (rd_data)
    );

    useq_next #(.AW(AW)) u_next (
        .cur    (mpc),
        .cond   (br_cond_e'(mir[COND_LSB +: COND_W])),
        .target (mir[AW-1:0]),
        .flag_n (flag_n),
        .flag_z (flag_z),
        .nxt    (nxt)
    );

    useq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .nxt        (nxt),
        .rd_data    (rd_data),
        .flag_n     (flag_n),
        .flag_z     (flag_z),
        .fetch_addr (fetch_addr),
        .mpc_q      (mpc),
        .mir_q      (mir)
    );

endmodule

// File: tb/useq_sequencer_tb_top.sv
module useq_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_we = 1'b0;
    logic [7:0]  cs_waddr = '0;
    logic [31:0] cs_wdata = '0;
    logic        flag_n = 1'b0;
    logic        flag_z = 1'b0;
    logic [7:0]  mpc;
    logic [31:0] mir;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] model [256];
    logic [7:0]  exp_mpc;
    logic [31:0] exp_mir;
    logic [15:0] lf = 16'hACE1;

    always #4 clk = ~clk;

    useq_sequencer dut_i (
        .clk(clk), .rst(rst), .cs_we(cs_we), .cs_waddr(cs_waddr),
        .cs_wdata(cs_wdata), .flag_n(flag_n), .flag_z(flag_z),
        .mpc(mpc), .mir(mir)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] step(input logic [31:0] w, input logic [7:0] pc,
                                        input logic n, input logic z);
        logic [7:0] inc;
        inc = pc + 8'd1;
        case (w[30:29])
            2'd0:    return inc;
            2'd1:    return n ? w[7:0] : inc;
            2'd2:    return z ? w[7:0] : inc;
            default: return w[7:0];
        endcase
    endfunction

    function automatic string tag_of(input logic [31:0] w);
        case (w[30:29])
            2'd0:    return "R4";
            2'd1:    return "R5";
            2'd2:    return "R6";
            default: return "R7";
        endcase
    endfunction

    // Writes one word while in reset; called at a falling edge
    task automatic load_word(input logic [7:0] a, input logic [31:0] d);
        cs_we = 1'b1; cs_waddr = a; cs_wdata = d;
        model[a] = d;
        @(negedge clk);
        cs_we = 1'b0;
    endtask

    // Releases reset at a falling edge and runs ncyc further edges
    task automatic run(input int ncyc, input bit phase_a);
        logic [7:0] nx;
        string      t;
        rst = 1'b0;
        @(negedge clk);
        chk("R2 mpc", {24'd0, mpc}, 32'd0);
        chk("R2 mir", mir, model[0]);
        exp_mpc = 8'd0;
        exp_mir = model[0];
        for (int k = 0; k < ncyc; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            flag_n = lf[3];
            flag_z = lf[9];
            cs_we = phase_a && (k == 10);
            cs_waddr = 8'd5;
            cs_wdata = 32'h1234_5678;
            nx = step(exp_mir, exp_mpc, flag_n, flag_z);
            t = tag_of(exp_mir);
            if (exp_mpc == 8'd255 && exp_mir[30:29] == 2'd0) t = "R4 wrap";
            @(negedge clk);
            cs_we = 1'b0;
            exp_mpc = nx;
            exp_mir = model[nx];
            chk(t, {24'd0, mpc}, {24'd0, exp_mpc});
            if (phase_a && k > 200 && exp_mpc == 8'd5)
                chk("R9 write ignored", mir, exp_mir);
            else
                chk("R3 fetch", mir, exp_mir);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 mpc", {24'd0, mpc}, 32'd0);
        chk("R1 mir", mir, 32'd0);

        // Phase A: sequential program, condition 0 everywhere (R8 loads)
        for (int i = 0; i < 256; i++) begin
            load_word(8'(i), {3'b000, 5'd0, 8'(i) ^ 8'h5A, ~8'(i), 8'(i)});
        end
        chk("R1 mpc after load", {24'd0, mpc}, 32'd0);
        chk("R1 mir after load", mir, 32'd0);
        run(300, 1'b1);

        // Reset in the middle of a run
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-run mpc", {24'd0, mpc}, 32'd0);
        chk("R1 mid-run mir", mir, 32'd0);

        // Phase B: mixed branch program
        for (int i = 0; i < 256; i++) begin
            logic [7:0] tg;
            tg = 8'((i * 37 + 11) % 256);
            load_word(8'(i), {1'b0, 2'(i % 4), 13'(i * 13), 8'(i), tg});
        end
        run(3000, 1'b0);

        // Phase C: branch-only chain overwritten in part (R8 rewrite)
        rst = 1'b1;
        @(negedge clk);
        load_word(8'd0, {1'b0, 2'd3, 21'd0, 8'd200});
        load_word(8'd200, {1'b0, 2'd2, 21'd7, 8'd255});
        load_word(8'd255, {1'b0, 2'd0, 21'd9, 8'd17});
        run(600, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule